// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit resolves the operand of an accumulator-style instruction. It takes the instruction's mode code, its address field, a register-select field and a pointer-level count. It then walks whatever reads that mode requires: none, one register read, one memory read, or a chain of memory reads. When the walk is complete it returns the final operand together with the effective address it used. A single done pulse marks that result.

The register file is read through a combinational select/data port. The word memory is synchronous and answers each one-cycle request with a valid strobe some cycles later, so the unit holds the address steady until the strobe arrives. A new operation is accepted only while the unit is idle. Pointer chains are bounded by a build-time maximum depth, and an out-of-range level count is reported as an error rather than walked.

Top module: `ea_resolver`

## Requirements
- R1: Mode code 0 (immediate) returns the address field, zero-extended, as the operand and as the effective address, with no memory request.
- R2: Mode code 1 (direct) issues exactly one memory request, at the address field, and returns that word as the operand; the effective address is the address field.
- R3: Mode code 2 (indirect) with level count L (L = 0 is treated as 1) performs L pointer reads and then one operand read, L+1 requests in total. Each pointer read takes the low address-width bits of the word just read as the next address. The effective address is the address of the final read.
- R4: Mode code 3 (register) returns the selected register as the operand, with the select value zero-extended as the effective address and no memory request.
- R5: Mode code 4 (register indirect) issues exactly one request, at the low address-width bits of the selected register, and that address is the effective address.
- R6: Mode code 5 (displacement) issues exactly one request, at the address field plus the low bits of the selected register, wrapping modulo 2^AW.
- R7: Mode codes 6 and 7 finish with the illegal-mode flag set, operand and effective address zero, and no memory request.
- R8: Indirect mode with a level count above MAX_DEPTH finishes with the depth-error flag set, operand and effective address zero, and no memory request.
- R9: Done is high for exactly one cycle per accepted operation, and operand, effective address and both flags are valid in that cycle.
- R10: A start pulse while busy is ignored: it neither changes the running result nor produces an extra done.
- R11: Each memory request is a one-cycle pulse raised only while busy, and the request address stays constant until the matching valid strobe.
- R12: During and right after reset, busy, done and the memory request are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 3 | Addressing mode code |
| addr_field | input | AW | Instruction address / immediate field |
| reg_sel | input | RSW | Register-select field |
| ind_levels | input | LVL_W | Pointer levels for indirect mode |
| rf_sel | output | RSW | Register file read select |
| rf_data | input | DW | Register file read data (combinational) |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | AW | Memory read address |
| mem_valid | input | 1 | Memory read data valid strobe |
| mem_rdata | input | DW | Memory read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| operand | output | DW | Resolved operand |
| eff_addr | output | AW | Effective address used |
| err_mode | output | 1 | Illegal mode code seen |
| err_depth | output | 1 | Pointer chain longer than allowed |

## Verification
The bench uses AW = 8, DW = 16, eight registers, MAX_DEPTH = 4 and a 3-bit level field. The narrow address makes displacement wrap-around reachable with small operands. The level field can express 5 to 7, so both the deepest legal chain and the over-depth error fall in range. Memory latency is varied between one and three cycles, which exercises both back-to-back pointer hops and the address hold while a read is outstanding.

// File: rtl/ea_pkg.sv
package ea_pkg;

  localparam logic [2:0] MODE_IMM  = 3'd0;
  localparam logic [2:0] MODE_DIR  = 3'd1;
  localparam logic [2:0] MODE_IND  = 3'd2;
  localparam logic [2:0] MODE_REG  = 3'd3;
  localparam logic [2:0] MODE_RIND = 3'd4;
  localparam logic [2:0] MODE_DISP = 3'd5;

  typedef struct packed {
    logic illegal;
    logic immediate;
    logic reg_operand;
    logic addr_from_reg;
    logic add_disp;
    logic chain;
  } ea_plan_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVAL  = 2'd1,
    ST_FETCH = 2'd2
  } ea_state_e;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_pkg::*;
(
  input  logic [2:0] mode,
  output ea_plan_t   plan
);
  always_comb begin
    plan = '0;
    unique case (mode)
      MODE_IMM:  plan.immediate = 1'b1;
      MODE_DIR:  ;
      MODE_IND:  plan.chain = 1'b1;
      MODE_REG:  plan.reg_operand = 1'b1;
      MODE_RIND: plan.addr_from_reg = 1'b1;
      MODE_DISP: begin
        plan.addr_from_reg = 1'b1;
        plan.add_disp      = 1'b1;
      end
      default:   plan.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/ea_addr_add.sv
module ea_addr_add #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] sum
);
  // carry out is dropped: the address space wraps
  assign sum = base + offset;
endmodule

// File: rtl/ea_chain_ctr.sv
module ea_chain_ctr #(
  parameter int LVL_W     = 3,
  parameter int MAX_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             chain_en,
  input  logic [LVL_W-1:0] levels,
  input  logic             dec,
  output logic             last,
  output logic             too_deep
);
  logic [LVL_W-1:0] left_q;
  logic [LVL_W-1:0] load_val;

  always_comb begin
    if (!chain_en)            load_val = '0;
    else if (levels == '0)    load_val = LVL_W'(1);
    else                      load_val = levels;
  end

  assign too_deep = chain_en && (int'(levels) > MAX_DEPTH);
  assign last     = (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst)       left_q <= '0;
    else if (load) left_q <= load_val;
    else if (dec)  left_q <= left_q - LVL_W'(1);
  end
endmodule

// File: rtl/ea_resolver.sv
module ea_resolver
  import ea_pkg::*;
#(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int NREG      = 8,
  parameter int MAX_DEPTH = 4,
  parameter int LVL_W     = 3,
  parameter int RSW       = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       mode,
  input  logic [AW-1:0]    addr_field,
  input  logic [RSW-1:0]   reg_sel,
  input  logic [LVL_W-1:0] ind_levels,
  output logic [RSW-1:0]   rf_sel,
  input  logic [DW-1:0]    rf_data,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_valid,
  input  logic [DW-1:0]    mem_rdata,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    operand,
  output logic [AW-1:0]    eff_addr,
  output logic             err_mode,
  output logic             err_depth
);

  ea_state_e        state_q;
  logic [2:0]       mode_q;
  logic [AW-1:0]    addr_q;
  logic [RSW-1:0]   sel_q;
  logic [LVL_W-1:0] lvl_q;

  logic             req_q, done_q, err_mode_q, err_depth_q;
  logic [AW-1:0]    maddr_q, ea_q;
  logic [DW-1:0]    opnd_q;

  ea_plan_t         plan;
  logic [AW-1:0]    disp_sum;
  logic [AW-1:0]    first_addr;
  logic             chain_last, chain_too_deep, chain_load, chain_dec;

  ea_mode_decode u_dec (
    .mode (mode_q),
    .plan (plan)
  );

  ea_addr_add #(.AW(AW)) u_add (
    .base   (addr_q),
    .offset (rf_data[AW-1:0]),
    .sum    (disp_sum)
  );

  assign chain_load = (state_q == ST_EVAL);
  assign chain_dec  = (state_q == ST_FETCH) && mem_valid && !chain_last;

  ea_chain_ctr #(.LVL_W(LVL_W), .MAX_DEPTH(MAX_DEPTH)) u_chain (
    .clk      (clk),
    .rst      (rst),
    .load     (chain_load),
    .chain_en (plan.chain),
    .levels   (lvl_q),
    .dec      (chain_dec),
    .last     (chain_last),
    .too_deep (chain_too_deep)
  );

  always_comb begin
    if (plan.addr_from_reg) first_addr = plan.add_disp ? disp_sum : rf_data[AW-1:0];
    else                    first_addr = addr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      mode_q      <= '0;
      addr_q      <= '0;
      sel_q       <= '0;
      lvl_q       <= '0;
      req_q       <= 1'b0;
      maddr_q     <= '0;
      done_q      <= 1'b0;
      opnd_q      <= '0;
      ea_q        <= '0;
      err_mode_q  <= 1'b0;
      err_depth_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      req_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            mode_q      <= mode;
            addr_q      <= addr_field;
            sel_q       <= reg_sel;
            lvl_q       <= ind_levels;
            err_mode_q  <= 1'b0;
            err_depth_q <= 1'b0;
            state_q     <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (plan.illegal || chain_too_deep) begin
            err_mode_q  <= plan.illegal;
            err_depth_q <= chain_too_deep;
            opnd_q      <= '0;
            ea_q        <= '0;
            done_q      <= 1'b1;
            state_q     <= ST_IDLE;
          end else if (plan.immediate) begin
            opnd_q  <= DW'(addr_q);
            ea_q    <= addr_q;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (plan.reg_operand) begin
            opnd_q  <= rf_data;
            ea_q    <= AW'(sel_q);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            maddr_q <= first_addr;
            req_q   <= 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (mem_valid) begin
            if (!chain_last) begin
              maddr_q <= mem_rdata[AW-1:0];
              req_q   <= 1'b1;
            end else begin
              opnd_q  <= mem_rdata;
              ea_q    <= maddr_q;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rf_sel    = sel_q;
  assign mem_req   = req_q;
  assign mem_addr  = maddr_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign operand   = opnd_q;
  assign eff_addr  = ea_q;
  assign err_mode  = err_mode_q;
  assign err_depth = err_depth_q;

endmodule

// File: rtl/ea_resolver_chk.sv
module ea_resolver_chk #(
  parameter int LVL_W     = 3,
  parameter int MAX_DEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [2:0]       mode,
  input logic [LVL_W-1:0] ind_levels,
  input logic             busy,
  input logic             done,
  input logic             mem_req,
  input logic             err_mode,
  input logic             err_depth
);
  logic             accept;
  logic [2:0]       mode_l;
  logic [LVL_W-1:0] lvl_l;
  logic [7:0]       rd_cnt;
  int               eff_lvl;

  assign accept  = start && !busy;
  assign eff_lvl = (lvl_l == '0) ? 1 : int'(lvl_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_l <= '0;
      lvl_l  <= '0;
      rd_cnt <= '0;
    end else if (accept) begin
      mode_l <= mode;
      lvl_l  <= ind_levels;
      rd_cnt <= '0;
    end else if (mem_req) begin
      rd_cnt <= rd_cnt + 8'd1;
    end
  end

  p_imm_noread_r1: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd0 |-> rd_cnt == 8'd0);
  p_direct_one_read_r2: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd1 |-> rd_cnt == 8'd1);
  p_chain_reads_r3: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd2 && !err_depth |-> int'(rd_cnt) == eff_lvl + 1);
  p_reg_noread_r4: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd3 |-> rd_cnt == 8'd0);
  p_regind_one_read_r5: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd4 |-> rd_cnt == 8'd1);
  p_disp_one_read_r6: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd5 |-> rd_cnt == 8'd1);
  p_illegal_noread_r7: assert property (@(posedge clk) disable iff (rst)
    done && mode_l > 3'd5 |-> err_mode && rd_cnt == 8'd0);
  p_too_deep_r8: assert property (@(posedge clk) disable iff (rst)
    done && mode_l == 3'd2 && int'(lvl_l) > MAX_DEPTH |-> err_depth && rd_cnt == 8'd0);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);
  p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  p_reset_quiet_r12: assert property (@(posedge clk)
    rst |=> !busy && !done && !mem_req);

endmodule

bind ea_resolver ea_resolver_chk #(.LVL_W(LVL_W), .MAX_DEPTH(MAX_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .mode       (mode),
  .ind_levels (ind_levels),
  .busy       (busy),
  .done       (done),
  .mem_req    (mem_req),
  .err_mode   (err_mode),
  .err_depth  (err_depth)
);

// File: tb/sim_ea_resolver.sv
module sim_ea_resolver;
  localparam int AW = 8, DW = 16, NREG = 8, MAXD = 4, LW = 3, RSW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic           start = 1'b0;
  logic [2:0]     mode = '0;
  logic [AW-1:0]  addr_field = '0;
  logic [RSW-1:0] reg_sel = '0;
  logic [LW-1:0]  ind_levels = '0;
  logic [RSW-1:0] rf_sel;
  logic [DW-1:0]  rf_data;
  logic           mem_req, mem_valid;
  logic [AW-1:0]  mem_addr;
  logic [DW-1:0]  mem_rdata;
  logic           busy, done, err_mode, err_depth;
  logic [DW-1:0]  operand;
  logic [AW-1:0]  eff_addr;

  ea_resolver #(.AW(AW), .DW(DW), .NREG(NREG), .MAX_DEPTH(MAXD), .LVL_W(LW)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .addr_field(addr_field),
    .reg_sel(reg_sel), .ind_levels(ind_levels), .rf_sel(rf_sel), .rf_data(rf_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .busy(busy), .done(done), .operand(operand), .eff_addr(eff_addr),
    .err_mode(err_mode), .err_depth(err_depth));

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] mem  [1 << AW];
  assign rf_data = regs[rf_sel];

  // memory model with adjustable latency
  int            mem_lat = 1;
  int            lat_cnt = 0;
  bit            pending = 0;
  logic [AW-1:0] pend_addr = '0;
  initial begin mem_valid = 1'b0; mem_rdata = '0; end
  always @(posedge clk) begin
    mem_valid <= 1'b0;
    if (mem_req) begin
      pending   <= 1'b1;
      pend_addr <= mem_addr;
      lat_cnt   <= mem_lat - 1;
    end else if (pending) begin
      if (lat_cnt == 0) begin
        mem_valid <= 1'b1;
        mem_rdata <= mem[pend_addr];
        pending   <= 1'b0;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  typedef struct {
    logic [DW-1:0] op;
    logic [AW-1:0] ea;
    logic          em;
    logic          ed;
    int            reads;
    string         tag;
  } exp_t;
  exp_t exp_q [$];

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [AW-1:0] a,
                                 input logic [RSW-1:0] s, input logic [LW-1:0] l);
    exp_t e;
    logic [AW-1:0] p;
    int lv;
    e.op = '0; e.ea = '0; e.em = 1'b0; e.ed = 1'b0; e.reads = 0;
    case (m)
      3'd0: begin e.op = DW'(a); e.ea = a; end
      3'd1: begin e.ea = a; e.op = mem[a]; e.reads = 1; end
      3'd2: begin
        if (int'(l) > MAXD) e.ed = 1'b1;
        else begin
          lv = (l == 0) ? 1 : int'(l);
          p = a;
          for (int i = 0; i < lv; i++) p = mem[p][AW-1:0];
          e.ea = p; e.op = mem[p]; e.reads = lv + 1;
        end
      end
      3'd3: begin e.op = regs[s]; e.ea = AW'(s); end
      3'd4: begin e.ea = regs[s][AW-1:0]; e.op = mem[e.ea]; e.reads = 1; end
      3'd5: begin e.ea = a + regs[s][AW-1:0]; e.op = mem[e.ea]; e.reads = 1; end
      default: e.em = 1'b1;
    endcase
    return e;
  endfunction

  // monitor / scoreboard
  int            rd_seen = 0;
  bit            prev_done = 0, prev_req = 0, waiting = 0;
  logic [AW-1:0] wait_addr = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (waiting) begin
        check(mem_addr == wait_addr, "R11", "address held", mem_addr, wait_addr);
        if (mem_valid) waiting = 0;
      end
      if (mem_req) begin
        rd_seen++;
        waiting   = 1;
        wait_addr = mem_addr;
        if (prev_req) check(0, "R11", "request longer than one cycle", 1, 0);
      end
      if (done) begin
        if (prev_done) check(0, "R9", "done held two cycles", 1, 0);
        if (exp_q.size() == 0) check(0, "R10", "unexpected done", 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          check(operand == e.op, e.tag, "operand", operand, e.op);
          check(eff_addr == e.ea, e.tag, "effective address", eff_addr, e.ea);
          check(err_mode == e.em, e.tag, "illegal flag", err_mode, e.em);
          check(err_depth == e.ed, e.tag, "depth flag", err_depth, e.ed);
          check(rd_seen == e.reads, e.tag, "read count", rd_seen, e.reads);
        end
        rd_seen = 0;
      end
      prev_done = done;
      prev_req  = mem_req;
    end
  end

  task automatic run_op(input logic [2:0] m, input logic [AW-1:0] a,
                        input logic [RSW-1:0] s, input logic [LW-1:0] l,
                        input string tag, input bit noise);
    exp_t e;
    e = model(m, a, s, l);
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1; mode = m; addr_field = a; reg_sel = s; ind_levels = l;
    @(negedge clk);
    start = 1'b0;
    if (noise) begin
      // R10: junk start requests while busy
      for (int k = 0; k < 4 && busy; k++) begin
        start = 1'b1; mode = 3'd0; addr_field = 8'hAA; reg_sel = 3'd7; ind_levels = '0;
        @(negedge clk);
      end
      start = 1'b0;
    end
    while (busy) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = {8'(i ^ 8'h5A), 8'(i * 37 + 11)};
    regs[0] = 16'h1234; regs[1] = 16'hA5C3; regs[2] = 16'h0F30; regs[3] = 16'h77FE;
    regs[4] = 16'h0001; regs[5] = 16'hBEEF; regs[6] = 16'h0080; regs[7] = 16'hFFFF;

    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_req, "R12", "idle during reset", {busy, done, mem_req}, 0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !mem_req && !err_mode && !err_depth, "R12", "idle after reset",
          {busy, done, mem_req, err_mode, err_depth}, 0);

    run_op(3'd0, 8'h3C, 3'd0, 3'd0, "R1", 0);
    run_op(3'd0, 8'hFF, 3'd5, 3'd7, "R1", 0);
    run_op(3'd1, 8'h10, 3'd0, 3'd0, "R2", 0);
    run_op(3'd1, 8'hFF, 3'd0, 3'd0, "R2", 0);
    run_op(3'd2, 8'h20, 3'd0, 3'd1, "R3", 0);
    run_op(3'd2, 8'h21, 3'd0, 3'd0, "R3", 0);
    run_op(3'd2, 8'h05, 3'd0, 3'd2, "R3", 0);
    run_op(3'd2, 8'h99, 3'd0, 3'd4, "R3", 0);
    run_op(3'd2, 8'h20, 3'd0, 3'd5, "R8", 0);
    run_op(3'd2, 8'h20, 3'd0, 3'd7, "R8", 0);
    run_op(3'd3, 8'h00, 3'd1, 3'd0, "R4", 0);
    run_op(3'd3, 8'h00, 3'd7, 3'd0, "R4", 0);
    run_op(3'd4, 8'h00, 3'd2, 3'd0, "R5", 0);
    run_op(3'd5, 8'h20, 3'd0, 3'd0, "R6", 0);
    run_op(3'd5, 8'hF0, 3'd3, 3'd0, "R6", 0);   // 0xF0 + 0xFE wraps to 0xEE
    run_op(3'd6, 8'h12, 3'd1, 3'd0, "R7", 0);
    run_op(3'd7, 8'h34, 3'd2, 3'd2, "R7", 0);

    mem_lat = 3;
    run_op(3'd2, 8'h44, 3'd0, 3'd3, "R10", 1);
    run_op(3'd1, 8'h80, 3'd0, 3'd0, "R11", 1);
    run_op(3'd5, 8'h7F, 3'd6, 3'd0, "R6", 0);
    run_op(3'd2, 8'h01, 3'd0, 3'd4, "R11", 0);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9", "results outstanding", exp_q.size(), 0);
    finish_run();
  end
endmodule